// File: doc/BRIEF.md
# Register-Mapped Level Interrupt Controller with Claim and Complete

This block collects level interrupt requests from a set of sources and presents one interrupt line per context (a processor and privilege level pair). Each source has a small programmable priority, each context has its own bitmap of enabled sources and a priority threshold, and a context's line is raised whenever some pending, unclaimed, enabled source has a priority strictly above that context's threshold.

Software serves an interrupt in two steps. Reading the claim register of a context returns the identifier of the lowest-numbered qualifying source, and that source moves from pending to claimed. A claimed source is excluded from every context's claims and lines until software writes its identifier back to a complete register. Identifier 0 is reserved and means "nothing to claim". All registers sit behind a single-word bus port with a request, a write strobe and an error flag; the response arrives one cycle after the request.

Top module: `irq_ctl`

## Requirements
- R1: After reset every source priority, pending bit, claimed bit, enable bit and context threshold is zero; bus_ack, bus_err, bus_rdata and irq_out are all low.
- R2: The word at byte PRIO_BASE+4k (0 <= k < NSRC-1) holds the priority of source k+1; a write keeps wdata bits [2:0] only and a read returns that value zero-extended. Source 0 has no priority register and its priority stays 0.
- R3: A rising src_lvl[i] sets pending bit i and a falling src_lvl[i] clears it; src_lvl[0] is ignored and pending bit 0 reads 0. Pending bits are read at byte PEND_BASE+4w, bit j showing source 32w+j.
- R4: A write to the pending region reports bus_err and changes no pending, claimed, enable, priority or threshold state.
- R5: The enable word w of context c is at byte EN_BASE + c*EN_STRIDE + 4w (EN_STRIDE a power of two); bit j enables source 32w+j. Word indices of ceil(NSRC/32) or more are not mapped.
- R6: irq_out[c] is high exactly when some source is pending, not claimed, enabled for c and has a priority strictly above the threshold of c; it reflects the state after each clock edge.
- R7: A read of byte CTX_BASE + c*CTX_STRIDE + 4 returns the lowest source ID qualifying for context c (as in R6), clears its pending bit and sets its claimed bit; if none qualifies it returns 0 and changes nothing. A level fall of the claimed source in the same cycle leaves it not pending.
- R8: A write of value v to the claim byte of any context clears claimed bit v when v < NSRC; a value of NSRC or more is ignored without error.
- R9: The threshold of context c is at byte CTX_BASE + c*CTX_STRIDE; a written value no larger than MAX_PRIO is stored, a larger one is ignored without error.
- R10: A misaligned address, an address in no region, an unmapped enable word and a context offset other than 0 or 4 raise bus_err, read as 0, and a write there changes no state.
- R11: bus_ack is high in the cycle after each request and low otherwise; bus_err and bus_rdata belong to that request and are 0 after writes and idle cycles; register effects appear at the clock edge that samples the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NSRC | Level request per source; bit 0 unused |
| bus_req | input | 1 | Access request, one word |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Access error for the acknowledged request |
| bus_rdata | output | 32 | Read data for the acknowledged request |
| irq_out | output | NCTX | Interrupt line per context |

## Verification
The two functions that meet in one cycle are a claim read and a level change on a source input. The bench provokes this by letting the claimed source fall in the very cycle of its claim, and by raising a fresh source in the cycle of a claim that finds nothing; it expects the claim to choose from the state before the edge, the fallen source to end neither pending nor re-claimable, and the freshly raised source to be returned only by the following claim. Every cycle the behavioural model's response and interrupt lines are compared with the ports.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   typedef enum logic [2:0] {
      REG_NONE  = 3'd0,
      REG_PRIO  = 3'd1,
      REG_PEND  = 3'd2,
      REG_EN    = 3'd3,
      REG_THR   = 3'd4,
      REG_CLAIM = 3'd5
   } reg_kind_e;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
   import irq_ctl_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int NSRC       = 40,
   parameter int NCTX       = 2,
   parameter int PRIO_BASE  = 'h0000,
   parameter int PEND_BASE  = 'h1000,
   parameter int EN_BASE    = 'h2000,
   parameter int EN_STRIDE  = 'h80,
   parameter int CTX_BASE   = 'h4000,
   parameter int CTX_STRIDE = 'h1000,
   localparam int WORDS  = (NSRC + 31) / 32,
   localparam int SRC_W  = $clog2(NSRC),
   localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_kind_e         kind,
   output logic [SRC_W-1:0]  src_idx,
   output logic [WORD_W-1:0] word_idx,
   output logic [CTX_W-1:0]  ctx_idx
);
   localparam int EN_SH  = $clog2(EN_STRIDE);
   localparam int CTX_SH = $clog2(CTX_STRIDE);

   logic [31:0] a;
   logic [31:0] off;
   logic [31:0] inner;

   assign a = 32'(addr);

   always_comb begin
      kind     = REG_NONE;
      src_idx  = '0;
      word_idx = '0;
      ctx_idx  = '0;
      off      = '0;
      inner    = '0;
      if (a[1:0] == 2'b00) begin
         if (a >= PRIO_BASE && a < PRIO_BASE + (NSRC - 1) * 4) begin
            off     = a - PRIO_BASE;
            kind    = REG_PRIO;
            src_idx = SRC_W'((off >> 2) + 1);
         end else if (a >= PEND_BASE && a < PEND_BASE + WORDS * 4) begin
            off      = a - PEND_BASE;
            kind     = REG_PEND;
            word_idx = WORD_W'(off >> 2);
         end else if (a >= EN_BASE && a < EN_BASE + NCTX * EN_STRIDE) begin
            off     = a - EN_BASE;
            inner   = off & (EN_STRIDE - 1);
            ctx_idx = CTX_W'(off >> EN_SH);
            if ((inner >> 2) < WORDS) begin
               kind     = REG_EN;
               word_idx = WORD_W'(inner >> 2);
            end
         end else if (a >= CTX_BASE && a < CTX_BASE + NCTX * CTX_STRIDE) begin
            off     = a - CTX_BASE;
            inner   = off & (CTX_STRIDE - 1);
            ctx_idx = CTX_W'(off >> CTX_SH);
            if (inner == 32'd0)      kind = REG_THR;
            else if (inner == 32'd4) kind = REG_CLAIM;
         end
      end
   end
endmodule

// File: rtl/irq_ctl_gate.sv
module irq_ctl_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic take,
   output logic pend
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         lvl_q <= lvl;
         if (take)               pend <= 1'b0;
         else if (lvl && !lvl_q) pend <= 1'b1;
         else if (!lvl && lvl_q) pend <= 1'b0;
      end
   end

   assert_fall_clears_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl && lvl_q) |=> !pend);
endmodule

// File: rtl/irq_ctl_pick.sv
module irq_ctl_pick #(
   parameter int NSRC   = 40,
   parameter int PRIO_W = 3,
   localparam int SRC_W = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]        avail,
   input  logic [NSRC-1:0]        en,
   input  logic [NSRC*PRIO_W-1:0] prio,
   input  logic [PRIO_W-1:0]      thr,
   output logic                   hit,
   output logic [SRC_W-1:0]       id
);
   always_comb begin
      hit = 1'b0;
      id  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (avail[i] && en[i] && (prio[i*PRIO_W +: PRIO_W] > thr)) begin
            hit = 1'b1;
            id  = SRC_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
   import irq_ctl_pkg::*;
#(
   parameter int NSRC       = 40,
   parameter int NCTX       = 2,
   parameter int PRIO_W     = 3,
   parameter int MAX_PRIO   = 7,
   parameter int ADDR_W     = 16,
   parameter int PRIO_BASE  = 'h0000,
   parameter int PEND_BASE  = 'h1000,
   parameter int EN_BASE    = 'h2000,
   parameter int EN_STRIDE  = 'h80,
   parameter int CTX_BASE   = 'h4000,
   parameter int CTX_STRIDE = 'h1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_lvl,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ack,
   output logic              bus_err,
   output logic [31:0]       bus_rdata,
   output logic [NCTX-1:0]   irq_out
);
   localparam int WORDS  = (NSRC + 31) / 32;
   localparam int SRC_W  = $clog2(NSRC);
   localparam int WORD_W = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;

   if (NSRC < 2) begin : g_bad_nsrc
      $error("NSRC must be at least 2");
   end
   if ((EN_STRIDE & (EN_STRIDE - 1)) != 0 || EN_STRIDE < WORDS * 4) begin : g_bad_en
      $error("EN_STRIDE must be a power of two holding all enable words");
   end
   if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0 || CTX_STRIDE < 8) begin : g_bad_ctx
      $error("CTX_STRIDE must be a power of two of at least 8");
   end
   if (MAX_PRIO >= (1 << PRIO_W) || PRIO_W > 32) begin : g_bad_prio
      $error("MAX_PRIO must fit in PRIO_W bits");
   end

   reg_kind_e         kind;
   logic [SRC_W-1:0]  src_idx;
   logic [WORD_W-1:0] word_idx;
   logic [CTX_W-1:0]  ctx_idx;

   irq_ctl_decode #(
      .ADDR_W(ADDR_W), .NSRC(NSRC), .NCTX(NCTX),
      .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
      .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE),
      .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
   ) u_decode (
      .addr(bus_addr), .kind(kind), .src_idx(src_idx),
      .word_idx(word_idx), .ctx_idx(ctx_idx)
   );

   logic [PRIO_W-1:0]      prio_q [NSRC];
   logic [NSRC*PRIO_W-1:0] prio_flat;
   logic [NSRC-1:0]        claimed_q;
   logic [NSRC-1:0]        en_q [NCTX];
   logic [PRIO_W-1:0]      thr_q [NCTX];
   logic [NSRC-1:0]        pend;
   logic [NSRC-1:0]        take;
   logic [NCTX-1:0]        sel_hit;
   logic [SRC_W-1:0]       sel_id [NCTX];

   logic wr, rd, claim_fire, bad;
   logic [SRC_W-1:0] claim_id;
   logic [31:0]      rd_val;

   assign wr         = bus_req && bus_we;
   assign rd         = bus_req && !bus_we;
   assign claim_id   = sel_id[ctx_idx];
   assign claim_fire = rd && (kind == REG_CLAIM) && sel_hit[ctx_idx];
   assign bad        = bus_req && ((kind == REG_NONE) || (bus_we && kind == REG_PEND));

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
         take[i] = claim_fire && (SRC_W'(i) == claim_id);
      end
   end

   // Per-source level gateway; identifier 0 is reserved.
   logic unused_src0;
   assign unused_src0 = src_lvl[0];
   assign pend[0]     = 1'b0;
   for (genvar i = 1; i < NSRC; i++) begin : g_src
      irq_ctl_gate u_gate (
         .clk(clk), .rst_n(rst_n), .lvl(src_lvl[i]),
         .take(take[i]), .pend(pend[i])
      );
   end

   // Per-context selection of the lowest qualifying identifier.
   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      irq_ctl_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
         .avail(pend & ~claimed_q), .en(en_q[c]), .prio(prio_flat),
         .thr(thr_q[c]), .hit(sel_hit[c]), .id(sel_id[c])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q[c]  <= '0;
            thr_q[c] <= '0;
         end else if (wr && CTX_W'(c) == ctx_idx) begin
            if (kind == REG_EN) begin
               for (int b = 0; b < NSRC; b++)
                  if (WORD_W'(b / 32) == word_idx) en_q[c][b] <= bus_wdata[b % 32];
            end
            if (kind == REG_THR && bus_wdata <= 32'(MAX_PRIO))
               thr_q[c] <= PRIO_W'(bus_wdata);
         end
      end

      assert_thr_range_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         32'(thr_q[c]) <= 32'(MAX_PRIO));
   end

   assign irq_out = sel_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
         claimed_q <= '0;
      end else begin
         for (int i = 1; i < NSRC; i++) begin
            if (wr && kind == REG_PRIO && SRC_W'(i) == src_idx)
               prio_q[i] <= bus_wdata[PRIO_W-1:0];
         end
         for (int i = 0; i < NSRC; i++) begin
            if (take[i]) claimed_q[i] <= 1'b1;
            else if (wr && kind == REG_CLAIM && bus_wdata == 32'(i)) claimed_q[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_val = '0;
      case (kind)
         REG_PRIO: begin
            for (int i = 0; i < NSRC; i++)
               if (SRC_W'(i) == src_idx) rd_val = 32'(prio_q[i]);
         end
         REG_PEND: begin
            for (int b = 0; b < NSRC; b++)
               if (WORD_W'(b / 32) == word_idx) rd_val[b % 32] = pend[b];
         end
         REG_EN: begin
            for (int b = 0; b < NSRC; b++)
               if (WORD_W'(b / 32) == word_idx) rd_val[b % 32] = en_q[ctx_idx][b];
         end
         REG_THR:   rd_val = 32'(thr_q[ctx_idx]);
         REG_CLAIM: rd_val = sel_hit[ctx_idx] ? 32'(claim_id) : 32'd0;
         default:   rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_err   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= bus_req;
         bus_err   <= bad;
         bus_rdata <= (rd && !bad) ? rd_val : 32'd0;
      end
   end

   assert_ack_follows_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ack);
   assert_err_reads_zero_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == 32'd0));
   assert_claim_moves_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      claim_fire |=> (claimed_q[$past(claim_id)] && !pend[$past(claim_id)]));
   assert_pend_write_inert_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && kind == REG_PEND) |=> $stable(claimed_q));
endmodule

// File: tb/test_irq_ctl.sv
module test_irq_ctl;
   localparam int NSRC = 40;
   localparam int NCTX = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src_lvl = '0;
   logic              bus_req = 1'b0;
   logic              bus_we = 1'b0;
   logic [15:0]       bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic              bus_ack;
   logic              bus_err;
   logic [31:0]       bus_rdata;
   logic [NCTX-1:0]   irq_out;

   irq_ctl i_irq_ctl (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   // behavioural reference state
   int m_prio [NSRC];
   bit m_pend [NSRC];
   bit m_clm  [NSRC];
   bit m_prev [NSRC];
   bit m_en   [NCTX][NSRC];
   int m_thr  [NCTX];
   logic [NSRC-1:0] src_drv = '0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int pick(input int c);
      for (int i = 1; i < NSRC; i++)
         if (m_pend[i] && !m_clm[i] && m_en[c][i] && m_prio[i] > m_thr[c]) return i;
      return 0;
   endfunction

   task automatic step(input bit req, input bit we, input logic [15:0] a,
                       input logic [31:0] d, input string tag);
      int kind, sidx, widx, cidx, cid;
      int ai;
      bit exp_err;
      logic [31:0] exp_rd;
      @(negedge clk);
      bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d; src_lvl = src_drv;
      ai = int'(a);
      kind = 0; sidx = 0; widx = 0; cidx = 0; cid = 0;
      if (ai % 4 == 0) begin
         if (ai < (NSRC - 1) * 4) begin
            kind = 1; sidx = ai / 4 + 1;
         end else if (ai >= 'h1000 && ai < 'h1008) begin
            kind = 2; widx = (ai - 'h1000) / 4;
         end else if (ai >= 'h2000 && ai < 'h2100) begin
            cidx = (ai - 'h2000) / 'h80; widx = ((ai - 'h2000) % 'h80) / 4;
            if (widx < 2) kind = 3;
         end else if (ai >= 'h4000 && ai < 'h6000) begin
            cidx = (ai - 'h4000) / 'h1000;
            if ((ai - 'h4000) % 'h1000 == 0) kind = 4;
            else if ((ai - 'h4000) % 'h1000 == 4) kind = 5;
         end
      end
      exp_err = 1'b0; exp_rd = '0;
      if (req) begin
         if (kind == 0 || (we && kind == 2)) exp_err = 1'b1;
         else if (!we) begin
            case (kind)
               1: exp_rd = 32'(m_prio[sidx]);
               2: for (int j = 0; j < 32; j++) if (32*widx + j < NSRC) exp_rd[j] = m_pend[32*widx + j];
               3: for (int j = 0; j < 32; j++) if (32*widx + j < NSRC) exp_rd[j] = m_en[cidx][32*widx + j];
               4: exp_rd = 32'(m_thr[cidx]);
               default: begin cid = pick(cidx); exp_rd = 32'(cid); end
            endcase
         end else begin
            case (kind)
               1: m_prio[sidx] = int'(d & 32'h7);
               3: for (int j = 0; j < 32; j++) if (32*widx + j < NSRC) m_en[cidx][32*widx + j] = d[j];
               4: if (d <= 32'd7) m_thr[cidx] = int'(d);
               default: if (d < 32'(NSRC)) m_clm[int'(d)] = 1'b0;
            endcase
         end
      end
      for (int i = 1; i < NSRC; i++) begin
         if (src_drv[i] && !m_prev[i]) m_pend[i] = 1'b1;
         if (!src_drv[i] && m_prev[i]) m_pend[i] = 1'b0;
         m_prev[i] = src_drv[i];
      end
      if (cid > 0) begin m_pend[cid] = 1'b0; m_clm[cid] = 1'b1; end
      @(posedge clk);
      #1;
      check(tag, "ack", 32'(bus_ack), 32'(req));
      check(tag, "err", 32'(bus_err), 32'(exp_err));
      check(tag, "rdata", bus_rdata, exp_rd);
      for (int c = 0; c < NCTX; c++)
         check("R6", $sformatf("irq_out[%0d]", c), 32'(irq_out[c]), 32'(pick(c) != 0));
   endtask

   task automatic rd(input logic [15:0] a, input string tag);
      step(1'b1, 1'b0, a, 32'd0, tag);
   endtask
   task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
      step(1'b1, 1'b1, a, d, tag);
   endtask
   task automatic idle(input string tag);
      step(1'b0, 1'b0, 16'd0, 32'd0, tag);
   endtask

   function automatic logic [15:0] a_prio(input int s);   return 16'((s - 1) * 4); endfunction
   function automatic logic [15:0] a_pend(input int w);   return 16'('h1000 + 4 * w); endfunction
   function automatic logic [15:0] a_en(input int c, input int w); return 16'('h2000 + c * 'h80 + 4 * w); endfunction
   function automatic logic [15:0] a_thr(input int c);    return 16'('h4000 + c * 'h1000); endfunction
   function automatic logic [15:0] a_clm(input int c);    return 16'('h4004 + c * 'h1000); endfunction

   initial begin
      #(4 * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < NSRC; i++) begin
         m_prio[i] = 0; m_pend[i] = 0; m_clm[i] = 0; m_prev[i] = 0;
         for (int c = 0; c < NCTX; c++) m_en[c][i] = 0;
      end
      for (int c = 0; c < NCTX; c++) m_thr[c] = 0;
      repeat (3) @(negedge clk);
      check("R1", "ack in reset", 32'(bus_ack), 32'd0);
      check("R1", "irq in reset", 32'(irq_out), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "rdata after reset", bus_rdata, 32'd0);
      rd(a_prio(1), "R1"); rd(a_en(0, 0), "R1"); rd(a_thr(1), "R1");
      rd(a_clm(0), "R1"); rd(a_pend(0), "R1");

      wr(a_prio(1), 32'hFF, "R2"); rd(a_prio(1), "R2");
      wr(a_prio(5), 32'h0B, "R2"); rd(a_prio(5), "R2");
      wr(a_prio(39), 32'h2, "R2"); rd(a_prio(39), "R2");

      wr(a_en(0, 0), 32'h22, "R5"); wr(a_en(1, 1), 32'h80, "R5");
      rd(a_en(1, 1), "R5"); rd(a_en(0, 1), "R5"); rd(a_en(0, 0), "R5");
      rd(a_en(0, 2), "R10");

      src_drv[5] = 1'b1; src_drv[0] = 1'b1;
      idle("R3"); rd(a_pend(0), "R3");

      wr(a_pend(0), 32'hFFFF_FFFF, "R4"); rd(a_pend(0), "R4"); rd(a_pend(1), "R4");

      wr(a_thr(0), 32'd3, "R9"); wr(a_thr(0), 32'd9, "R9"); rd(a_thr(0), "R9");
      wr(a_thr(0), 32'd2, "R9"); rd(a_thr(0), "R9");

      src_drv[1] = 1'b1; idle("R3");
      rd(a_clm(0), "R7"); rd(a_clm(0), "R7"); rd(a_clm(0), "R7"); rd(a_pend(0), "R7");

      wr(a_clm(0), 32'd1, "R8"); rd(a_clm(0), "R8");
      src_drv[1] = 1'b0; idle("R3"); src_drv[1] = 1'b1; idle("R3");
      rd(a_clm(0), "R8");
      wr(a_clm(0), 32'd45, "R8");
      src_drv[5] = 1'b0; idle("R3"); src_drv[5] = 1'b1; idle("R3");
      rd(a_clm(0), "R8");
      wr(a_clm(0), 32'd5, "R8"); rd(a_clm(0), "R8");

      src_drv[39] = 1'b1; idle("R6");
      rd(a_clm(1), "R7"); wr(a_clm(1), 32'd39, "R8"); rd(a_pend(1), "R3");

      // claim read in the same cycle as level changes
      wr(a_clm(0), 32'd5, "R8");
      src_drv[5] = 1'b0; idle("R3"); src_drv[5] = 1'b1; idle("R3");
      wr(a_clm(0), 32'd5, "R8");
      src_drv[5] = 1'b0; rd(a_clm(0), "R7"); rd(a_pend(0), "R7");
      wr(a_clm(0), 32'd5, "R8"); rd(a_clm(0), "R7");
      wr(a_clm(0), 32'd1, "R8");
      src_drv[1] = 1'b0; idle("R3");
      src_drv[1] = 1'b1; rd(a_clm(0), "R7"); rd(a_clm(0), "R7");

      rd(16'h0002, "R10"); wr(16'h0006, 32'h7, "R10"); rd(a_prio(2), "R10");
      rd(16'h3000, "R10"); rd(16'h4008, "R10");
      wr(16'h5008, 32'd1, "R10"); rd(a_thr(1), "R10");
      rd(16'h00FC, "R10");

      idle("R11"); idle("R11");
      wr(a_en(0, 0), 32'h0, "R11"); idle("R11");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule